// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block produces the system reset of a chip from three sources: a supply-alive indication, a digitized power-good level from an external trip-point comparator, and a watchdog that monitors a serial-bus chip-select line. Reset is held through power-up and through every brownout. It is released only after power-good has stayed high, without interruption, for a long fixed hold interval given in clock cycles.

The watchdog has a two-bit select field that chooses one of three timeout lengths or switches the watchdog off. Only a falling edge of chip select restarts its count. A chip select that is stuck high or stuck low therefore times out, and the timeout raises reset for the same hold interval used at power-up.

The asynchronous power-good and chip-select inputs are synchronized through two flip-flops inside the block. A parameter selects the polarity of the reset output. The analog comparator, trip-point trimming and the output pad lie outside this block.

Top module: `supply_reset_seq`

## Requirements
- R1: While `supply_ok` is low, the reset output is asserted at once, without waiting for a clock edge, and all internal state is cleared.
- R2: After power-good rises (or `supply_ok` is released with power-good already high), reset stays asserted through clock edge HOLD_CYCLES+1 and deasserts on edge HOLD_CYCLES+2. Edges are counted from the first rising clock edge after the change.
- R3: A fall of power-good during operation asserts reset on the 3rd rising edge after the fall, not earlier.
- R4: Any drop of power-good during the hold interval restarts the hold count from zero. Release then comes HOLD_CYCLES+2 edges after the final rise.
- R5: Watchdog select codes are 2'b01 for WD_SHORT cycles, 2'b10 for WD_MID cycles and 2'b11 for WD_LONG cycles. An enabled watchdog asserts reset on the period-th rising edge after the last edge at which its count was cleared.
- R6: A falling edge of `cs_n_a` clears the watchdog count on the 3rd rising edge after the fall. With no further falling edge, reset asserts period+3 edges after the fall, whether chip select then stays low or high. Falling edges that arrive faster than the period prevent any timeout.
- R7: Select code 2'b00 disables the watchdog and holds its count cleared. Re-enabling starts a full new period.
- R8: A watchdog timeout holds reset for exactly HOLD_CYCLES edges and then releases it, as long as power-good stays high.
- R9: With ACTIVE_LOW=1 the output is low while reset is asserted. With ACTIVE_LOW=0 it is high while reset is asserted.
- R10: The watchdog count is held cleared while reset is asserted. After a release with chip select stuck high, a timeout comes on the period-th edge after the release edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running block clock |
| supply_ok | input | 1 | Supply above the minimum operating level; low clears the block asynchronously |
| pwr_good_a | input | 1 | Asynchronous comparator output, high when the supply is above the trip point |
| cs_n_a | input | 1 | Asynchronous serial-bus chip select, active low, watched by the watchdog |
| wd_sel | input | 2 | Watchdog period select: 00 off, 01 short, 10 mid, 11 long |
| sys_rst | output | 1 | System reset, polarity set by ACTIVE_LOW |

## Verification
Every result is due a known number of rising edges after its stimulus. A power-good fall reaches the output on the 3rd edge (two synchronizer stages plus the reset flag). Release comes on edge HOLD_CYCLES+2 after a rise. A chip-select falling edge clears the count on the 3rd edge, so a timeout lands period+3 edges after the fall. A timeout-driven reset lasts HOLD_CYCLES edges.

The bench drives inputs on falling clock edges and samples 2 ns after a counted rising edge. It checks each boundary on both sides: one edge before the due edge, where the old value must still hold, and on the due edge itself, where the new value must appear. The watchdog cases come from a table of select code, edge count and expected reset level. Directed sequences then cover brownout, a power-good glitch during the hold, re-enabling the watchdog and the stuck-high case after a release.

// File: rtl/supply_reset_seq.sv
module supply_reset_seq #(
  parameter int unsigned HOLD_CYCLES = 2_000_000,
  parameter int unsigned WD_SHORT    = 1_500_000,
  parameter int unsigned WD_MID      = 6_000_000,
  parameter int unsigned WD_LONG     = 14_000_000,
  parameter bit          ACTIVE_LOW  = 1'b1
) (
  input  logic       clk,
  input  logic       supply_ok,
  input  logic       pwr_good_a,
  input  logic       cs_n_a,
  input  logic [1:0] wd_sel,
  output logic       sys_rst
);

  localparam int unsigned WD_MAX0 = (WD_SHORT > WD_MID) ? WD_SHORT : WD_MID;
  localparam int unsigned WD_MAX  = (WD_MAX0 > WD_LONG) ? WD_MAX0 : WD_LONG;
  localparam int unsigned HW      = $clog2(HOLD_CYCLES + 1);
  localparam int unsigned WW      = $clog2(WD_MAX + 1);
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYCLES - 1);

  logic          pg_s1, pg_s2;
  logic          cs_s1, cs_s2, cs_s3;
  logic          rst_active;
  logic [HW-1:0] hold_cnt;
  logic [WW-1:0] wd_cnt, wd_last;
  logic          wd_en, kick, wd_fire;

  always_ff @(posedge clk or negedge supply_ok) begin
    if (!supply_ok) begin
      pg_s1 <= 1'b0;
      pg_s2 <= 1'b0;
      cs_s1 <= 1'b1;
      cs_s2 <= 1'b1;
      cs_s3 <= 1'b1;
    end else begin
      pg_s1 <= pwr_good_a;
      pg_s2 <= pg_s1;
      cs_s1 <= cs_n_a;
      cs_s2 <= cs_s1;
      cs_s3 <= cs_s2;
    end
  end

  assign wd_en = |wd_sel;
  assign kick  = cs_s3 & ~cs_s2;

  always_comb begin
    case (wd_sel)
      2'b01:   wd_last = WW'(WD_SHORT - 1);
      2'b10:   wd_last = WW'(WD_MID - 1);
      2'b11:   wd_last = WW'(WD_LONG - 1);
      default: wd_last = '0;
    endcase
  end

  assign wd_fire = wd_en & ~rst_active & ~kick & (wd_cnt == wd_last);

  always_ff @(posedge clk or negedge supply_ok) begin
    if (!supply_ok) begin
      wd_cnt <= '0;
    end else if (!wd_en || rst_active || kick || wd_fire) begin
      wd_cnt <= '0;
    end else begin
      wd_cnt <= wd_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge supply_ok) begin
    if (!supply_ok) begin
      rst_active <= 1'b1;
      hold_cnt   <= '0;
    end else if (!pg_s2 || wd_fire) begin
      rst_active <= 1'b1;
      hold_cnt   <= '0;
    end else if (rst_active) begin
      if (hold_cnt == HOLD_LAST) begin
        rst_active <= 1'b0;
        hold_cnt   <= '0;
      end else begin
        hold_cnt <= hold_cnt + 1'b1;
      end
    end
  end

  assign sys_rst = ACTIVE_LOW ? ~rst_active : rst_active;

  // Checker-only: length of the current unbroken power-good run, saturating.
  logic [HW-1:0] good_run;
  always_ff @(posedge clk or negedge supply_ok) begin
    if (!supply_ok)                      good_run <= '0;
    else if (!pg_s2)                     good_run <= '0;
    else if (good_run != HW'(HOLD_CYCLES)) good_run <= good_run + 1'b1;
  end

  p_release_after_hold_r2: assert property (@(posedge clk) disable iff (!supply_ok)
    $fell(rst_active) |-> (good_run == HW'(HOLD_CYCLES)));

  p_pg_loss_restarts_r4: assert property (@(posedge clk) disable iff (!supply_ok)
    !pg_s2 |=> (rst_active && hold_cnt == '0));

  p_timeout_resets_r5: assert property (@(posedge clk) disable iff (!supply_ok)
    wd_fire |=> (rst_active && hold_cnt == '0));

  p_kick_clears_r6: assert property (@(posedge clk) disable iff (!supply_ok)
    kick |=> (wd_cnt == '0));

  p_disabled_idle_r7: assert property (@(posedge clk) disable iff (!supply_ok)
    !wd_en |=> (wd_cnt == '0));

  p_no_count_in_reset_r10: assert property (@(posedge clk) disable iff (!supply_ok)
    rst_active |=> (wd_cnt == '0));

endmodule

// File: tb/supply_reset_seq_bench.sv
module supply_reset_seq_bench;
  localparam int H  = 40;
  localparam int T1 = 20;
  localparam int T2 = 50;
  localparam int T3 = 100;
  localparam int NV = 7;
  localparam int VSEL  [0:NV-1] = '{1, 1, 2, 2, 3, 3, 0};
  localparam int VWAIT [0:NV-1] = '{T1+2, T1+3, T2+2, T2+3, T3+2, T3+3, 150};
  localparam int VEXP  [0:NV-1] = '{0, 1, 0, 1, 0, 1, 0};

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       supply_ok = 1'b0;
  logic       pg = 1'b1;
  logic       cs_n = 1'b1;
  logic [1:0] sel = 2'b00;
  logic       rst_lo, rst_hi;
  int n_chk = 0;
  int n_bad = 0;

  supply_reset_seq #(.HOLD_CYCLES(H), .WD_SHORT(T1), .WD_MID(T2), .WD_LONG(T3),
                     .ACTIVE_LOW(1'b1)) u_supply_reset_seq (
    .clk(clk), .supply_ok(supply_ok), .pwr_good_a(pg), .cs_n_a(cs_n),
    .wd_sel(sel), .sys_rst(rst_lo));

  supply_reset_seq #(.HOLD_CYCLES(H), .WD_SHORT(T1), .WD_MID(T2), .WD_LONG(T3),
                     .ACTIVE_LOW(1'b0)) u_supply_reset_seq_hi (
    .clk(clk), .supply_ok(supply_ok), .pwr_good_a(pg), .cs_n_a(cs_n),
    .wd_sel(sel), .sys_rst(rst_hi));

  task automatic chk(input string req, input bit exp_on);
    n_chk++;
    if ((rst_lo !== ~exp_on) || (rst_hi !== exp_on)) begin
      n_bad++;
      $display("FAIL %s: low-variant=%b high-variant=%b expected low=%b high=%b",
               req, rst_lo, rst_hi, ~exp_on, exp_on);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic at_neg;
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run hung, got running expected finished");
    finish_run();
  end

  initial begin
    // R1 / R9: supply not alive
    at_neg();
    chk("R1 reset state", 1'b1);
    supply_ok = 1'b1;
    edges(H + 1);
    chk("R2 still held at edge H+1", 1'b1);
    edges(1);
    chk("R2 released at edge H+2", 1'b0);

    // Watchdog table: R5 / R6 / R7
    for (int i = 0; i < NV; i++) begin
      at_neg();
      sel  = 2'(VSEL[i]);
      cs_n = 1'b0;
      edges(VWAIT[i]);
      chk(VSEL[i] == 0 ? "R7 disabled, no timeout" :
          (VEXP[i] != 0 ? "R6 timeout at period+3" : "R5 no timeout at period+2"),
          VEXP[i] != 0);
      at_neg();
      sel  = 2'b00;
      cs_n = 1'b1;
      edges(H + 10);
      chk("R8 released after timeout reset", 1'b0);
    end

    // R6: kicks faster than the period
    at_neg();
    sel = 2'b01;
    for (int k = 0; k < 12; k++) begin
      at_neg();
      cs_n = 1'b0;
      edges(8);
      at_neg();
      cs_n = 1'b1;
      edges(8);
      chk("R6 regular kicks hold off timeout", 1'b0);
    end
    at_neg();
    sel = 2'b00;
    edges(5);

    // R7: disabling clears the count
    at_neg();
    sel = 2'b10;
    edges(40);
    at_neg();
    sel = 2'b00;
    edges(2);
    at_neg();
    sel = 2'b10;
    edges(T2 - 1);
    chk("R7 re-enable restarts full period", 1'b0);
    edges(1);
    chk("R7 timeout after full new period", 1'b1);
    at_neg();
    sel = 2'b00;
    edges(H + 10);

    // R3: brownout latency
    at_neg();
    pg = 1'b0;
    edges(2);
    chk("R3 not yet asserted at edge 2", 1'b0);
    edges(1);
    chk("R3 asserted at edge 3", 1'b1);
    edges(5);
    // R4: glitch during hold
    at_neg();
    pg = 1'b1;
    edges(20);
    at_neg();
    pg = 1'b0;
    edges(3);
    at_neg();
    pg = 1'b1;
    edges(H + 1);
    chk("R4 glitch restarted hold, still held", 1'b1);
    edges(1);
    chk("R4 released after full hold", 1'b0);

    // R10 and R8: stuck-high chip select after release
    at_neg();
    pg = 1'b0;
    edges(5);
    at_neg();
    sel = 2'b01;
    pg  = 1'b1;
    edges(H + 2);
    chk("R10 released with watchdog enabled", 1'b0);
    edges(T1 - 1);
    chk("R10 no timeout before period after release", 1'b0);
    edges(1);
    chk("R10 timeout at period after release", 1'b1);
    at_neg();
    sel = 2'b00;
    edges(H - 1);
    chk("R8 timeout reset still held", 1'b1);
    edges(1);
    chk("R8 timeout reset lasts hold interval", 1'b0);

    // R1: asynchronous supply loss
    at_neg();
    supply_ok = 1'b0;
    #1;
    chk("R1 immediate assert on supply loss", 1'b1);

    finish_run();
  end
endmodule